// File: doc/BRIEF.md
# Fuse Bank Access Checker

This block sits between a fuse sequencer and a three-bank fuse array and decides, one request at a time, whether an access may go ahead. Five kinds of access are judged: a software read, an explicit sense, a program (burn), an override and a scan through the test port. Each bank carries a protect byte in its row 0, and a set of field-lock fuses guards particular row ranges. A denied access raises one reason bit and forces the returned data to zero.

Right after reset the block fetches the few fuse rows that hold protect and lock bits from the array, holds them in registers, and only then starts answering requests. These captured values stay fixed until the next reset, so a lock blown later takes effect only after reset. Each accepted request gets its verdict one clock later. The row-to-lock table lives in the package, so remapping it does not touch the logic.

Top module: `fz_access_chk`

## Requirements
- R1: After reset release the block issues exactly five array reads: bank 0 row 0, bank 1 row 0, bank 2 row 0, bank 0 row 1 and bank 0 row 17, one per cycle. Each read returns data one cycle later. `ready` rises after the last capture and stays high. No response is produced for a request made while `ready` is low.
- R2: A request accepted while `ready` is high yields `rsp_valid` on the next cycle. `rsp_err` has at most one bit set, and `rsp_allow` is high exactly when `rsp_err` is zero. Operation codes are: 0 read, 1 sense, 2 program, 3 override, 4 scan.
- R3: In the protect byte (row 0) of the addressed bank, a blown bit denies one operation for every row of that bank. Bit 7 denies program (err bit 0), bit 6 override (err bit 1), bit 5 read (err bit 2), bit 4 scan (err bit 3) and bit 3 sense (err bit 4).
- R4: Each ordinary field lock, when blown, denies program and override of its rows with err bit 5 and leaves read, sense and scan allowed. In bank 0 the locks are: row 0 bit 1 guarding row 7, row 1 bit 7 guarding row 1, row 17 bit 0 guarding rows 3–6, and row 17 bit 7 guarding rows 18–19.
- R5: In bank 2, row 0 bit 1 is an ordinary lock over rows 1–11 and row 0 bit 0 is an ordinary lock over rows 12–31.
- R6: Bank 1 rows 1–21 hold a secret key. Read, sense and scan of these rows are always denied with err bit 5. Program and override are allowed while bank 1 row 0 bit 0 is unblown and denied with err bit 5 once it is blown.
- R7: Bank 1 rows 23–29 hold a response value. When bank 1 row 0 bit 1 is blown, all five operations on these rows are denied with err bit 5.
- R8: An allowed read, sense or scan returns `req_rdata` on `rsp_rdata`. An allowed program or override returns zero, and every denied request returns zero.
- R9: The captured protect and lock values do not change after `ready` rises, and no further array reads are issued until the next reset.
- R10: A bank index of 3, or an operation code above 4, is denied with err bit 6.
- R11: When several reasons apply, only one is reported. A bad request wins over a bank protect bit, and a bank protect bit wins over a field lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_op | input | 3 | Operation code |
| req_bank | input | 2 | Addressed bank |
| req_row | input | 8 | Addressed row within the bank |
| req_rdata | input | 8 | Row data sensed by the array for this request |
| fa_rd_en | output | 1 | Load-time read strobe toward the array |
| fa_bank | output | 2 | Load-time read bank |
| fa_row | output | 8 | Load-time read row |
| fa_rdata | input | 8 | Array data, valid the cycle after `fa_rd_en` |
| ready | output | 1 | Protect and lock values captured |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access may proceed |
| rsp_err | output | 7 | One-hot denial reason |
| rsp_rdata | output | 8 | Masked row data |

## Verification
A bank protect bit and a field lock can both deny the same request. This happens, for example, when a program request hits bank 0 row 7 with both the bank write-protect bit and the revision lock blown. It also happens when a sense request hits a response row whose lock and the bank sense-protect bit are both blown. The bench loads such fuse images and checks that only the protect-bit reason appears. A bad bank index against a fully protected image shows the same ordering one level up. A lock fuse is also changed in the array model after `ready` rises. Requests to the rows it guards must keep their earlier verdict until a fresh reset reloads the image.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int BANK_W      = 2;
  localparam int ROW_W       = 8;
  localparam int DATA_W      = 8;
  localparam int OP_W        = 3;
  localparam int NUM_BANKS   = 3;
  localparam int LOAD_N      = 5;
  localparam int NUM_REGIONS = 8;
  localparam int SLOT_W      = $clog2(LOAD_N);

  localparam logic [OP_W-1:0] OP_READ  = 3'd0;
  localparam logic [OP_W-1:0] OP_SENSE = 3'd1;
  localparam logic [OP_W-1:0] OP_PROG  = 3'd2;
  localparam logic [OP_W-1:0] OP_OVRD  = 3'd3;
  localparam logic [OP_W-1:0] OP_SCAN  = 3'd4;

  // denial reason bit positions
  localparam int E_PROG  = 0;
  localparam int E_OVRD  = 1;
  localparam int E_READ  = 2;
  localparam int E_SCAN  = 3;
  localparam int E_SENSE = 4;
  localparam int E_LOCK  = 5;
  localparam int E_BAD   = 6;
  localparam int ERR_W   = 7;

  typedef enum logic [1:0] {
    LK_BURN,    // blocks burn and override only
    LK_SECRET,  // never readable, burn blocked once blown
    LK_HIDE     // everything blocked once blown
  } lock_kind_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  lo;
    logic [ROW_W-1:0]  hi;
    logic [SLOT_W-1:0] slot;
    logic [2:0]        bitpos;
    lock_kind_e        kind;
  } region_t;

  // capture slot i: slots 0..2 are row 0 of banks 0..2
  function automatic logic [BANK_W-1:0] load_bank(input int i);
    return (i < NUM_BANKS) ? BANK_W'(i) : '0;
  endfunction

  function automatic logic [ROW_W-1:0] load_row(input int i);
    case (i)
      3:       return ROW_W'(1);
      4:       return ROW_W'(17);
      default: return '0;
    endcase
  endfunction

  function automatic region_t region(input int i);
    region_t r;
    r = '0;
    case (i)
      0: begin r.bank = 2'd0; r.lo = 8'd7;  r.hi = 8'd7;  r.slot = 3'd0; r.bitpos = 3'd1; r.kind = LK_BURN;   end
      1: begin r.bank = 2'd0; r.lo = 8'd1;  r.hi = 8'd1;  r.slot = 3'd3; r.bitpos = 3'd7; r.kind = LK_BURN;   end
      2: begin r.bank = 2'd0; r.lo = 8'd3;  r.hi = 8'd6;  r.slot = 3'd4; r.bitpos = 3'd0; r.kind = LK_BURN;   end
      3: begin r.bank = 2'd0; r.lo = 8'd18; r.hi = 8'd19; r.slot = 3'd4; r.bitpos = 3'd7; r.kind = LK_BURN;   end
      4: begin r.bank = 2'd1; r.lo = 8'd1;  r.hi = 8'd21; r.slot = 3'd1; r.bitpos = 3'd0; r.kind = LK_SECRET; end
      5: begin r.bank = 2'd1; r.lo = 8'd23; r.hi = 8'd29; r.slot = 3'd1; r.bitpos = 3'd1; r.kind = LK_HIDE;   end
      6: begin r.bank = 2'd2; r.lo = 8'd1;  r.hi = 8'd11; r.slot = 3'd2; r.bitpos = 3'd1; r.kind = LK_BURN;   end
      default: begin r.bank = 2'd2; r.lo = 8'd12; r.hi = 8'd31; r.slot = 3'd2; r.bitpos = 3'd0; r.kind = LK_BURN; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fz_loader.sv
module fz_loader
  import fz_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          fa_rd_en,
  output logic [BANK_W-1:0]             fa_bank,
  output logic [ROW_W-1:0]              fa_row,
  input  logic [DATA_W-1:0]             fa_rdata,
  output logic [LOAD_N-1:0][DATA_W-1:0] slots,
  output logic                          ready
);
  localparam int CNT_W = $clog2(LOAD_N + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOAD_N);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(LOAD_N - 1);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] pidx_q;
  logic             pend_q;
  logic             ready_q, ready_d;
  logic             issue;

  assign issue = (idx_q < LIMIT);

  always_comb begin
    idx_d   = issue ? idx_q + CNT_W'(1) : idx_q;
    ready_d = ready_q | (pend_q && (pidx_q == LAST));
  end

  always_comb begin
    fa_bank = '0;
    fa_row  = '0;
    for (int i = 0; i < LOAD_N; i++) begin
      if (idx_q == CNT_W'(i)) begin
        fa_bank = load_bank(i);
        fa_row  = load_row(i);
      end
    end
  end

  assign fa_rd_en = issue;
  assign ready    = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      pidx_q  <= '0;
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      pidx_q  <= idx_q;
      pend_q  <= issue;
      ready_q <= ready_d;
    end
  end

  // capture slot with per-slot clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots <= '0;
    end else begin
      for (int s = 0; s < LOAD_N; s++) begin
        if (pend_q && (pidx_q == CNT_W'(s))) slots[s] <= fa_rdata;
      end
    end
  end
endmodule

// File: rtl/fz_prot_check.sv
module fz_prot_check
  import fz_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] prot,
  output logic [ERR_W-1:0]  deny
);
  logic unused_low;
  assign unused_low = ^prot[2:0];

  always_comb begin
    deny = '0;
    case (op)
      OP_PROG:  deny[E_PROG]  = prot[7];
      OP_OVRD:  deny[E_OVRD]  = prot[6];
      OP_READ:  deny[E_READ]  = prot[5];
      OP_SCAN:  deny[E_SCAN]  = prot[4];
      OP_SENSE: deny[E_SENSE] = prot[3];
      default:  deny = '0;
    endcase
  end
endmodule

// File: rtl/fz_lock_match.sv
module fz_lock_match
  import fz_pkg::*;
(
  input  logic [OP_W-1:0]               op,
  input  logic [BANK_W-1:0]             bank,
  input  logic [ROW_W-1:0]              row,
  input  logic [LOAD_N-1:0][DATA_W-1:0] slots,
  output logic                          deny
);
  logic [NUM_REGIONS-1:0] rgn_deny;
  logic is_burn, is_look;
  logic unused_slots;

  assign unused_slots = ^slots;
  assign is_burn = (op == OP_PROG) || (op == OP_OVRD);
  assign is_look = (op == OP_READ) || (op == OP_SENSE) || (op == OP_SCAN);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    localparam region_t RG = region(g);
    logic hit, blown;
    assign hit   = (bank == RG.bank) && (row >= RG.lo) && (row <= RG.hi);
    assign blown = slots[RG.slot][RG.bitpos];
    if (RG.kind == LK_BURN) begin : g_burn
      assign rgn_deny[g] = hit & blown & is_burn;
    end else if (RG.kind == LK_SECRET) begin : g_secret
      assign rgn_deny[g] = hit & (blown | is_look);
    end else begin : g_hide
      assign rgn_deny[g] = hit & blown;
    end
  end

  assign deny = |rgn_deny;
endmodule

// File: rtl/fz_access_chk.sv
module fz_access_chk
  import fz_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [OP_W-1:0]     req_op,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [DATA_W-1:0]   req_rdata,
  output logic                fa_rd_en,
  output logic [BANK_W-1:0]   fa_bank,
  output logic [ROW_W-1:0]    fa_row,
  input  logic [DATA_W-1:0]   fa_rdata,
  output logic                ready,
  output logic                rsp_valid,
  output logic                rsp_allow,
  output logic [ERR_W-1:0]    rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata
);
  logic [LOAD_N-1:0][DATA_W-1:0] slots;
  logic [DATA_W-1:0] prot_byte;
  logic [ERR_W-1:0]  prot_deny;
  logic              lock_deny;
  logic              bad;
  logic              take;
  logic              valid_d, allow_d;
  logic [ERR_W-1:0]  err_d;
  logic [DATA_W-1:0] rdata_d;

  fz_loader u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .fa_rd_en (fa_rd_en),
    .fa_bank  (fa_bank),
    .fa_row   (fa_row),
    .fa_rdata (fa_rdata),
    .slots    (slots),
    .ready    (ready)
  );

  assign bad       = (req_bank >= BANK_W'(NUM_BANKS)) || (req_op > OP_SCAN);
  assign prot_byte = bad ? '0 : slots[SLOT_W'(req_bank)];

  fz_prot_check u_prot (
    .op   (req_op),
    .prot (prot_byte),
    .deny (prot_deny)
  );

  fz_lock_match u_lock (
    .op    (req_op),
    .bank  (req_bank),
    .row   (req_row),
    .slots (slots),
    .deny  (lock_deny)
  );

  assign take = req_valid & ready;

  // next-state: priority bad > bank protect > field lock
  always_comb begin
    valid_d = take;
    err_d   = '0;
    if (bad)              err_d[E_BAD]  = 1'b1;
    else if (|prot_deny)  err_d         = prot_deny;
    else if (lock_deny)   err_d[E_LOCK] = 1'b1;
    allow_d = (err_d == '0);
    rdata_d = (allow_d && ((req_op == OP_READ) || (req_op == OP_SENSE) ||
                           (req_op == OP_SCAN))) ? req_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_err   <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid_d;
      if (take) begin
        rsp_allow <= allow_d;
        rsp_err   <= err_d;
        rsp_rdata <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/fz_access_chk_sva.sv
module fz_access_chk_sva
  import fz_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OP_W-1:0]   req_op,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic              fa_rd_en,
  input logic              ready,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic [ERR_W-1:0]  rsp_err,
  input logic [DATA_W-1:0] rsp_rdata
);
  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_no_early_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !rsp_valid);

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> rsp_valid);

  p_single_reason_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_err));

  p_mask_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_allow) |-> (rsp_rdata == '0));

  p_no_fetch_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !fa_rd_en);

  p_bad_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && (req_bank == 2'd3)) |=> (rsp_err[E_BAD] && !rsp_allow));

  p_key_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && (req_bank == 2'd1) && (req_op == OP_READ) &&
     (req_row >= 8'd1) && (req_row <= 8'd21)) |=> !rsp_allow);
endmodule

bind fz_access_chk fz_access_chk_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_bank  (req_bank),
  .req_row   (req_row),
  .fa_rd_en  (fa_rd_en),
  .ready     (ready),
  .rsp_valid (rsp_valid),
  .rsp_allow (rsp_allow),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/fz_access_chk_tb.sv
module fz_access_chk_tb;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_op;
  logic [1:0] req_bank;
  logic [7:0] req_row;
  logic [7:0] req_rdata;
  logic       fa_rd_en;
  logic [1:0] fa_bank;
  logic [7:0] fa_row;
  logic [7:0] fa_rdata;
  logic       ready;
  logic       rsp_valid;
  logic       rsp_allow;
  logic [6:0] rsp_err;
  logic [7:0] rsp_rdata;

  fz_access_chk u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_rdata(req_rdata),
    .fa_rd_en(fa_rd_en), .fa_bank(fa_bank), .fa_row(fa_row), .fa_rdata(fa_rdata),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fuse array model, one-cycle read latency
  logic [7:0] mem [0:2][0:31];
  always_ff @(posedge clk) begin
    if (fa_rd_en) fa_rdata <= mem[fa_bank][fa_row[4:0]];
  end

  typedef struct {
    logic       allow;
    logic [6:0] err;
    logic [7:0] rdata;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   n_fetch = 0;
  bit   done = 0;
  logic [7:0] s_prot [0:2];
  logic [7:0] s_r1, s_r17;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // expected verdict from the requirements
  function automatic exp_t model(input logic [2:0] op, input logic [1:0] bank,
                                 input logic [7:0] row, input logic [7:0] d, input string tag);
    exp_t e;
    logic [6:0] err;
    logic burn, look, lk;
    err  = '0;
    burn = (op == 3'd2) || (op == 3'd3);
    look = (op == 3'd0) || (op == 3'd1) || (op == 3'd4);
    if (bank == 2'd3 || op > 3'd4) err[6] = 1'b1;
    else begin
      case (op)
        3'd2: err[0] = s_prot[bank][7];
        3'd3: err[1] = s_prot[bank][6];
        3'd0: err[2] = s_prot[bank][5];
        3'd4: err[3] = s_prot[bank][4];
        default: err[4] = s_prot[bank][3];
      endcase
      if (err == '0) begin
        lk = 1'b0;
        if (bank == 2'd0) begin
          if (row == 8'd7 && s_prot[0][1]) lk = burn;
          if (row == 8'd1 && s_r1[7]) lk = burn;
          if (row >= 8'd3 && row <= 8'd6 && s_r17[0]) lk = burn;
          if (row >= 8'd18 && row <= 8'd19 && s_r17[7]) lk = burn;
        end else if (bank == 2'd1) begin
          if (row >= 8'd1 && row <= 8'd21) lk = look || s_prot[1][0];
          if (row >= 8'd23 && row <= 8'd29) lk = s_prot[1][1];
        end else begin
          if (row >= 8'd1 && row <= 8'd11 && s_prot[2][1]) lk = burn;
          if (row >= 8'd12 && row <= 8'd31 && s_prot[2][0]) lk = burn;
        end
        err[5] = lk;
      end
    end
    e.err   = err;
    e.allow = (err == '0);
    e.rdata = (e.allow && look) ? d : 8'h00;
    e.tag   = tag;
    return e;
  endfunction

  task automatic send(input logic [2:0] op, input logic [1:0] bank, input logic [7:0] row,
                      input logic [7:0] d, input string tag);
    req_valid = 1'b1; req_op = op; req_bank = bank; req_row = row; req_rdata = d;
    sb.push_back(model(op, bank, row, d, tag));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && fa_rd_en) n_fetch++;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected response", {25'd0, rsp_err}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check((rsp_allow === e.allow) && (rsp_err === e.err) && (rsp_rdata === e.rdata),
              e.tag, {15'd0, rsp_allow, rsp_rdata, 1'b0, rsp_err},
              {15'd0, e.allow, e.rdata, 1'b0, e.err});
      end
    end
  end

  task automatic do_reset(input string tag);
    req_valid = 1'b0; req_op = '0; req_bank = '0; req_row = '0; req_rdata = '0;
    rst_n = 1'b0;
    for (int b = 0; b < 3; b++) s_prot[b] = mem[b][0];
    s_r1 = mem[0][1]; s_r17 = mem[0][17];
    repeat (3) @(negedge clk);
    check(ready === 1'b0 && rsp_valid === 1'b0, {tag, " R1 reset state"}, {ready, rsp_valid}, 0);
    n_fetch = 0;
    rst_n = 1'b1;
    // request during load: must produce nothing (R1)
    req_valid = 1'b1; req_op = 3'd0; req_bank = 2'd0; req_row = 8'd2;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 20 && !ready; w++) @(negedge clk);
    @(negedge clk);
    check(ready === 1'b1, {tag, " R1 ready rises"}, ready, 1);
    check(n_fetch == 5, {tag, " R1 five array reads"}, n_fetch, 5);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    for (int b = 0; b < 3; b++) for (int r = 0; r < 32; r++) mem[b][r] = 8'h00;

    // image A: nothing blown
    do_reset("A");
    send(3'd0, 2'd0, 8'd9,  8'h5A, "R8 read passes data");
    send(3'd1, 2'd2, 8'd40, 8'hC3, "R8 sense passes data");
    send(3'd2, 2'd0, 8'd9,  8'h77, "R8 program returns zero");
    send(3'd4, 2'd1, 8'd25, 8'h3C, "R7 response scan while unlocked");
    send(3'd0, 2'd1, 8'd5,  8'h11, "R6 key read always denied");
    send(3'd4, 2'd1, 8'd21, 8'h11, "R6 key scan always denied");
    send(3'd2, 2'd1, 8'd1,  8'h11, "R6 key burn allowed while unlocked");
    send(3'd0, 2'd3, 8'd0,  8'h11, "R10 bank 3 rejected");
    send(3'd6, 2'd0, 8'd0,  8'h11, "R10 bad op rejected");
    idle(3);

    // image B: mixed protect and lock bits
    mem[0][0]  = 8'hA2;  // prog+read protect, revision lock
    mem[0][1]  = 8'h80;  // row-1 lock
    mem[0][17] = 8'h81;  // version lock + boot lock
    mem[1][0]  = 8'h0A;  // sense protect, response lock
    mem[2][0]  = 8'h51;  // override+scan protect, upper lock
    do_reset("B");
    send(3'd0, 2'd0, 8'd5,  8'h22, "R3 read protect bank0");
    send(3'd2, 2'd0, 8'd7,  8'h22, "R11 write protect over lock");
    send(3'd3, 2'd0, 8'd7,  8'h22, "R4 revision lock override");
    send(3'd1, 2'd0, 8'd1,  8'h99, "R4 locked row still sensable");
    send(3'd3, 2'd0, 8'd1,  8'h22, "R4 row-1 lock override");
    send(3'd3, 2'd0, 8'd4,  8'h22, "R4 boot lock override");
    send(3'd3, 2'd0, 8'd19, 8'h22, "R4 version lock override");
    send(3'd3, 2'd0, 8'd10, 8'h22, "R4 unguarded row override");
    send(3'd0, 2'd1, 8'd25, 8'h22, "R7 locked response read");
    send(3'd1, 2'd1, 8'd25, 8'h22, "R11 sense protect over response lock");
    send(3'd2, 2'd1, 8'd29, 8'h22, "R7 locked response program");
    send(3'd2, 2'd1, 8'd5,  8'h22, "R6 key burn with lock unblown");
    send(3'd3, 2'd2, 8'd3,  8'h22, "R3 override protect bank2");
    send(3'd2, 2'd2, 8'd3,  8'h22, "R5 lower lock unblown");
    send(3'd2, 2'd2, 8'd20, 8'h22, "R5 upper lock program");
    send(3'd0, 2'd2, 8'd20, 8'h6B, "R5 upper locked row readable");
    send(3'd4, 2'd2, 8'd20, 8'h22, "R3 scan protect bank2");
    send(3'd3, 2'd3, 8'd0,  8'h22, "R11 bad bank over protect");
    idle(3);

    // blow locks in the array without reset: verdicts unchanged (R9)
    mem[1][0] = 8'h0B;
    mem[2][0] = 8'h53;
    send(3'd2, 2'd1, 8'd5, 8'h22, "R9 key lock not reloaded");
    send(3'd2, 2'd2, 8'd3, 8'h22, "R9 bank2 lock not reloaded");
    idle(3);
    check(n_fetch == 5, "R9 no reads after ready", n_fetch, 5);

    // image C: reload picks up new locks
    do_reset("C");
    send(3'd2, 2'd1, 8'd5, 8'h22, "R6 key burn after lock blown");
    send(3'd3, 2'd1, 8'd21, 8'h22, "R6 key override after lock blown");
    send(3'd2, 2'd2, 8'd3, 8'h22, "R5 lower lock program");
    idle(4);
    check(sb.size() == 0, "R2 every request answered", sb.size(), 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule